// File: doc/BRIEF.md
# Button-Driven Cursor Position Controller

This block keeps the position of a cursor cell on a character grid 20 columns wide and 15 rows tall. Four raw push-button levels steer it: right, left, down and up. A press is accepted only after the button has been held continuously for a long qualifying time. Each accepted press moves the cursor by exactly one cell, and the position wraps around at the grid edges.

The block has two position registers. The internal X/Y pair changes as soon as a step is accepted. The published horizontal/vertical location is what the display logic reads, and it copies the internal pair only on clock edges where the vertical sync strobe is high. As a result, a frame that is being scanned never sees the cursor move.

Each button has its own hold qualifier. A qualifier is a four-state machine: IDLE goes to COUNT when the button goes high. COUNT goes back to IDLE on release, or goes to FIRE when the hold count reaches its limit. FIRE lasts one cycle and goes to LATCHED if the button is still held, or to IDLE if it is not. LATCHED goes to IDLE on release. The step machine has five states: NONE, RIGHT, LEFT, DOWN and UP. On every edge it enters the state of the highest-priority step pulse present, or NONE when no pulse is present. On the following edge, its output process applies the move that the state names to X or Y.

Top module: `cursor_nav_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, the internal position and the published outputs `hor_loc`/`ver_loc` are all zero.
- R2: A direction is accepted only when its button has been sampled high on HOLD_CYCLES consecutive clock edges. A shorter press is ignored. So is a press broken by any low sample: its count restarts from zero.
- R3: A press yields exactly one step, however long it is held past the limit. A new step needs the button to be released first.
- R4: Right adds one to the column (`hor_loc`). Left subtracts one from the column. Down adds one to the row (`ver_loc`). Up subtracts one from the row. One accepted step never changes both axes.
- R5: The position wraps at the edges. Column 19 goes to 0 on right, and column 0 goes to 19 on left. Row 14 goes to 0 on down, and row 0 goes to 14 on up.
- R6: If steps for several directions are accepted on the same edge, only one is applied. The priority is right, then left, then down, then up. The other steps are discarded.
- R7: On a clock edge where `vsync` is high, `hor_loc`/`ver_loc` load the internal position. On every other edge they hold their value. An accepted step reaches the internal position two edges after the step pulse appears.
- R8: The column never exceeds 19 and the row never exceeds 14, both internally and at the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| btn_right | input | 1 | Raw right button level |
| btn_left | input | 1 | Raw left button level |
| btn_down | input | 1 | Raw down button level |
| btn_up | input | 1 | Raw up button level |
| vsync | input | 1 | Frame strobe; allows the published location to load |
| hor_loc | output | X_W (5) | Published cursor column, 0 to 19 |
| ver_loc | output | Y_W (4) | Published cursor row, 0 to 14 |

## Verification
Several properties are checked on every cycle:
- the grid bounds hold;
- a step pulse lasts one cycle and only follows a high button sample;
- a move never touches both axes;
- a move away from the last column goes either to column 0 or to column 18;
- the published location loads on `vsync` and holds otherwise;
- reset clears every register.

Other behaviours show only in the bench's scenarios:
- presses one cycle short of the limit, and broken presses;
- presses held far past the limit;
- wrap-around on each axis;
- simultaneous presses resolved by priority;
- agreement between the published location and a model of the accepted presses over a long random run.

// File: rtl/cnav_pkg.sv
package cnav_pkg;

    // Button index order doubles as step priority: lower index wins.
    localparam int unsigned DIR_N     = 4;
    localparam int unsigned DIR_RIGHT = 0;
    localparam int unsigned DIR_LEFT  = 1;
    localparam int unsigned DIR_DOWN  = 2;
    localparam int unsigned DIR_UP    = 3;

    typedef enum logic [1:0] {
        HQ_IDLE,
        HQ_COUNT,
        HQ_FIRE,
        HQ_LATCHED
    } hold_state_e;

    typedef enum logic [2:0] {
        MV_NONE,
        MV_RIGHT,
        MV_LEFT,
        MV_DOWN,
        MV_UP
    } move_state_e;

endpackage

// File: rtl/cnav_hold_qual.sv
module cnav_hold_qual
    import cnav_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_i,
    output logic step_o
);

    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CYCLES - 1);
    localparam bit SINGLE = (HOLD_CYCLES <= 1);

    hold_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= HQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HQ_IDLE: begin
                if (btn_i) begin
                    state_d = SINGLE ? HQ_FIRE : HQ_COUNT;
                end
            end
            HQ_COUNT: begin
                if (!btn_i) begin
                    state_d = HQ_IDLE;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = HQ_FIRE;
                end
            end
            HQ_FIRE: begin
                state_d = btn_i ? HQ_LATCHED : HQ_IDLE;
            end
            HQ_LATCHED: begin
                if (!btn_i) begin
                    state_d = HQ_IDLE;
                end
            end
        endcase
    end

    // hold counter: number of consecutive high samples so far
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (state_d == HQ_COUNT) begin
            cnt_q <= (state_q == HQ_COUNT) ? cnt_q + 1'b1 : CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        step_o = (state_q == HQ_FIRE);
    end

endmodule

// File: rtl/cnav_step_fsm.sv
module cnav_step_fsm
    import cnav_pkg::*;
#(
    parameter int unsigned COLS = 20,
    parameter int unsigned ROWS = 15,
    parameter int unsigned X_W  = $clog2(COLS),
    parameter int unsigned Y_W  = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DIR_N-1:0] step_i,
    output logic [X_W-1:0] x_o,
    output logic [Y_W-1:0] y_o
);

    localparam logic [X_W-1:0] X_MAX = X_W'(COLS - 1);
    localparam logic [Y_W-1:0] Y_MAX = Y_W'(ROWS - 1);

    move_state_e state_q, state_d;
    logic [X_W-1:0] x_q;
    logic [Y_W-1:0] y_q;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= MV_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // priority decode of same-cycle steps
    always_comb begin
        if (step_i[DIR_RIGHT]) begin
            state_d = MV_RIGHT;
        end else if (step_i[DIR_LEFT]) begin
            state_d = MV_LEFT;
        end else if (step_i[DIR_DOWN]) begin
            state_d = MV_DOWN;
        end else if (step_i[DIR_UP]) begin
            state_d = MV_UP;
        end else begin
            state_d = MV_NONE;
        end
    end

    // output process: apply the move named by the state
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            unique case (state_q)
                MV_NONE:  ;
                MV_RIGHT: x_q <= (x_q == X_MAX) ? '0 : x_q + 1'b1;
                MV_LEFT:  x_q <= (x_q == '0) ? X_MAX : x_q - 1'b1;
                MV_DOWN:  y_q <= (y_q == Y_MAX) ? '0 : y_q + 1'b1;
                MV_UP:    y_q <= (y_q == '0) ? Y_MAX : y_q - 1'b1;
                default:  ;
            endcase
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

endmodule

// File: rtl/cnav_frame_latch.sv
module cnav_frame_latch #(
    parameter int unsigned X_W = 5,
    parameter int unsigned Y_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vsync,
    input  logic [X_W-1:0] x_i,
    input  logic [Y_W-1:0] y_i,
    output logic [X_W-1:0] hor_o,
    output logic [Y_W-1:0] ver_o
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hor_o <= '0;
            ver_o <= '0;
        end else if (vsync) begin
            hor_o <= x_i;
            ver_o <= y_i;
        end
    end

endmodule

// File: rtl/cursor_nav_ctrl.sv
module cursor_nav_ctrl
    import cnav_pkg::*;
#(
    parameter int unsigned COLS        = 20,
    parameter int unsigned ROWS        = 15,
    parameter int unsigned HOLD_CYCLES = 50_000_000,
    parameter int unsigned X_W         = $clog2(COLS),
    parameter int unsigned Y_W         = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           btn_right,
    input  logic           btn_left,
    input  logic           btn_down,
    input  logic           btn_up,
    input  logic           vsync,
    output logic [X_W-1:0] hor_loc,
    output logic [Y_W-1:0] ver_loc
);

    logic [DIR_N-1:0] btn_raw;
    logic [DIR_N-1:0] step_vec;
    logic [X_W-1:0]   x_pos;
    logic [Y_W-1:0]   y_pos;

    always_comb begin
        btn_raw            = '0;
        btn_raw[DIR_RIGHT] = btn_right;
        btn_raw[DIR_LEFT]  = btn_left;
        btn_raw[DIR_DOWN]  = btn_down;
        btn_raw[DIR_UP]    = btn_up;
    end

    for (genvar g = 0; g < DIR_N; g++) begin : g_qual
        cnav_hold_qual #(
            .HOLD_CYCLES(HOLD_CYCLES)
        ) u_qual (
            .clk   (clk),
            .rst   (rst),
            .btn_i (btn_raw[g]),
            .step_o(step_vec[g])
        );
    end

    cnav_step_fsm #(
        .COLS(COLS),
        .ROWS(ROWS),
        .X_W (X_W),
        .Y_W (Y_W)
    ) u_step (
        .clk   (clk),
        .rst   (rst),
        .step_i(step_vec),
        .x_o   (x_pos),
        .y_o   (y_pos)
    );

    cnav_frame_latch #(
        .X_W(X_W),
        .Y_W(Y_W)
    ) u_latch (
        .clk  (clk),
        .rst  (rst),
        .vsync(vsync),
        .x_i  (x_pos),
        .y_i  (y_pos),
        .hor_o(hor_loc),
        .ver_o(ver_loc)
    );

endmodule

// File: rtl/cnav_checker.sv
module cnav_checker #(
    parameter int unsigned COLS = 20,
    parameter int unsigned ROWS = 15,
    parameter int unsigned X_W  = 5,
    parameter int unsigned Y_W  = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [3:0]     btn_raw,
    input logic [3:0]     step_vec,
    input logic           vsync,
    input logic [X_W-1:0] x_pos,
    input logic [Y_W-1:0] y_pos,
    input logic [X_W-1:0] hor_loc,
    input logic [Y_W-1:0] ver_loc
);

    localparam logic [X_W-1:0] X_MAX = X_W'(COLS - 1);
    localparam logic [Y_W-1:0] Y_MAX = Y_W'(ROWS - 1);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (hor_loc == '0 && ver_loc == '0 && x_pos == '0 && y_pos == '0));

    for (genvar i = 0; i < 4; i++) begin : g_btn
        assert_step_needs_button_R2: assert property (@(posedge clk) disable iff (rst)
            step_vec[i] |-> $past(btn_raw[i]));
        assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
            step_vec[i] |=> !step_vec[i]);
    end

    assert_one_axis_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(x_pos) |-> $stable(y_pos));

    assert_column_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(x_pos) && $past(x_pos) == X_MAX) |-> (x_pos == '0 || x_pos == X_MAX - 1'b1));

    assert_vsync_load_R7: assert property (@(posedge clk) disable iff (rst)
        vsync |=> (hor_loc == $past(x_pos) && ver_loc == $past(y_pos)));

    assert_hold_between_frames_R7: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> ($stable(hor_loc) && $stable(ver_loc)));

    assert_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        (x_pos <= X_MAX && y_pos <= Y_MAX && hor_loc <= X_MAX && ver_loc <= Y_MAX));

endmodule

bind cursor_nav_ctrl cnav_checker #(
    .COLS(COLS),
    .ROWS(ROWS),
    .X_W (X_W),
    .Y_W (Y_W)
) u_cnav_checker (
    .clk     (clk),
    .rst     (rst),
    .btn_raw (btn_raw),
    .step_vec(step_vec),
    .vsync   (vsync),
    .x_pos   (x_pos),
    .y_pos   (y_pos),
    .hor_loc (hor_loc),
    .ver_loc (ver_loc)
);

// File: tb/cursor_nav_ctrl_bench.sv
`timescale 1ns/1ps
module cursor_nav_ctrl_bench;

    localparam int HOLD = 8;
    localparam int COLS = 20;
    localparam int ROWS = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_right = 1'b0, btn_left = 1'b0, btn_down = 1'b0, btn_up = 1'b0;
    logic vsync = 1'b0;
    logic [4:0] hor_loc;
    logic [3:0] ver_loc;

    int total = 0;
    int bad = 0;
    int exp_x = 0, exp_y = 0;
    int pub_x = 0, pub_y = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cursor_nav_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .HOLD_CYCLES(HOLD)
    ) u_cursor_nav_ctrl (
        .clk(clk), .rst(rst),
        .btn_right(btn_right), .btn_left(btn_left),
        .btn_down(btn_down), .btn_up(btn_up),
        .vsync(vsync), .hor_loc(hor_loc), .ver_loc(ver_loc)
    );

    // mask bit 0 right, 1 left, 2 down, 3 up; lowest set bit wins
    function automatic int winner(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int move_x(input int x, input int d);
        if (d == 0) return (x == COLS - 1) ? 0 : x + 1;
        if (d == 1) return (x == 0) ? COLS - 1 : x - 1;
        return x;
    endfunction

    function automatic int move_y(input int y, input int d);
        if (d == 2) return (y == ROWS - 1) ? 0 : y + 1;
        if (d == 3) return (y == 0) ? ROWS - 1 : y - 1;
        return y;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] m, input int len);
        @(negedge clk);
        {btn_up, btn_down, btn_left, btn_right} = m;
        repeat (len) @(negedge clk);
        {btn_up, btn_down, btn_left, btn_right} = 4'b0;
        if (len >= HOLD) begin
            exp_x = move_x(exp_x, winner(m));
            exp_y = move_y(exp_y, winner(m));
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic publish(input string req);
        @(negedge clk);
        check({req, " R7 hold"}, hor_loc, pub_x);
        check({req, " R7 hold"}, ver_loc, pub_y);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        pub_x = exp_x;
        pub_y = exp_y;
        check({req, " x"}, hor_loc, exp_x);
        check({req, " y"}, ver_loc, exp_y);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));
        repeat (3) @(negedge clk);
        check("R1 reset x", hor_loc, 0);
        check("R1 reset y", ver_loc, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset x", hor_loc, 0);

        press(4'b0001, HOLD - 1);                       // R2 too short
        publish("R2 short");
        press(4'b0001, HOLD - 1);                       // R2 broken press
        press(4'b0001, HOLD - 1);
        publish("R2 broken");
        press(4'b0001, HOLD);                           // R2 exact limit, R4 right
        publish("R4 right");
        press(4'b0001, 5 * HOLD);                       // R3 long hold, one step
        publish("R3 long");
        press(4'b0100, HOLD);                           // R4 down
        press(4'b0100, HOLD);
        press(4'b1000, HOLD);                           // R4 up (no vsync between: R7)
        publish("R4 down/up");
        press(4'b0010, HOLD);
        press(4'b0010, HOLD);
        press(4'b0010, HOLD);                           // R5 wrap 0 -> 19
        publish("R5 left wrap");
        press(4'b0001, HOLD);                           // R5 wrap 19 -> 0
        publish("R5 right wrap");
        press(4'b1000, HOLD);
        press(4'b1000, HOLD);                           // R5 wrap 0 -> 14
        publish("R5 up wrap");
        press(4'b0100, 2 * HOLD);                       // R5 wrap 14 -> 0
        publish("R5 down wrap");
        press(4'b0011, HOLD);                           // R6 right beats left
        publish("R6 right>left");
        press(4'b1100, HOLD);                           // R6 down beats up
        publish("R6 down>up");
        press(4'b1010, HOLD);                           // R6 left beats up
        publish("R6 left>up");

        for (int n = 0; n < 200; n++) begin
            logic [3:0] m;
            int len;
            m = 4'b0001 << ($urandom % 4);
            if (($urandom % 6) == 0) m = m | (4'b0001 << ($urandom % 4));
            len = HOLD - 2 + int'($urandom % (2 * HOLD));
            press(m, len);
            if (($urandom % 3) == 0) publish("R4 random");
        end
        publish("R8 random end");
        check("R8 range x", int'(hor_loc < COLS), 1);
        check("R8 range y", int'(ver_loc < ROWS), 1);

        @(negedge clk);
        rst = 1'b1;                                     // R1 reset mid-run
        exp_x = 0; exp_y = 0; pub_x = 0; pub_y = 0;
        @(negedge clk);
        check("R1 mid reset x", hor_loc, 0);
        check("R1 mid reset y", ver_loc, 0);
        rst = 1'b0;
        publish("R1 internal cleared");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule